// File: doc/BRIEF.md
# Sampling Peripheral Interrupt and Soft-Reset Register Block

This block is the register front end of a sampling peripheral. A converter core next to it raises one-cycle event pulses, such as end-of-conversion and end-of-sequence. The block captures each pulse in two places. The first is a status register that software reads to learn what happened, and reading it empties it. The second is an interrupt status register that software acknowledges by writing ones. A per-source mask and a global gate turn the interrupt status into a single level interrupt line.

Software reaches every register through a single-beat bus. The bus has a word address, a write strobe with write data, and a read strobe with read data. Read data is registered and appears in the cycle after the read strobe.

A key-protected software reset register produces a reset pulse of fixed length for the rest of the peripheral. While that pulse is high, all enable and status state in this block is forced to zero. A build parameter can remove the interrupt registers altogether.

Top module: `periph_irq_regs`

## Requirements
- R1: A write of 0x0000_000A to word address 0 drives `srst_o` high for exactly 16 consecutive cycles, starting in the cycle after the write.
- R2: A write to word address 0 with any value other than 0x0000_000A leaves `srst_o` low. Word address 0 always reads 0.
- R3: Word address 1 is the global enable. Only bit 31 is stored and read back, and all other bits read 0. While bit 31 is 0, `irq_o` is low.
- R4: Word address 2 is the source mask. Bits 7:0 are stored and read back, and bits 31:8 read 0.
- R5: A write to word address 3, the interrupt status, inverts every bit written as 1 and keeps every bit written as 0. An event arriving in the same cycle sets its bit after the inversion.
- R6: A high bit i on `evt_i` sets bit i of both the status register (word address 4) and the interrupt status register. Bit 0 is end-of-conversion and bit 1 is end-of-sequence.
- R7: A read of word address 4 returns the flags and clears them. A flag whose event arrives in the same cycle as that read stays set.
- R8: `irq_o` is high exactly when the global enable bit is 1 and any bit of (interrupt status AND mask) is 1.
- R9: While `srst_o` is high, `irq_o` is low. The global enable, mask, interrupt status and status registers are zero once the pulse ends, and writes and events during the pulse leave no trace.
- R10: With HAS_IRQ = 0, word addresses 1 to 3 read 0, writes to them have no effect, and `irq_o` stays low. The status register still behaves as in R6 and R7.
- R11: Read data is registered and valid in the cycle after `rd_en_i`. Word addresses 5 and above read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W (4) | Word address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Read data, valid in the cycle after rd_en_i |
| evt_i | input | EVT_W (8) | Event pulses from the converter core |
| irq_o | output | 1 | Level interrupt |
| srst_o | output | 1 | Software reset pulse to the rest of the peripheral |

## Verification
The hardest cases to reach are the cycle collisions. One is an event pulse landing in the same cycle as the status read that clears its flag. Another is an event landing in the same cycle as an acknowledge write to the interrupt status. A third is a register write and an event arriving partway through the reset pulse. The bench drives the event and bus strobes together from one falling edge, so both act on the same rising edge. It then reads the registers back after the pulse to confirm what survived. A sweep over all 256 event patterns, each paired with a derived mask, covers the latching, masking and toggle-acknowledge paths.

// File: rtl/pir_pkg.sv
package pir_pkg;
    localparam int DATA_W   = 32;
    localparam int OFS_SRST = 0;
    localparam int OFS_GIE  = 1;
    localparam int OFS_IER  = 2;
    localparam int OFS_ISR  = 3;
    localparam int OFS_STAT = 4;
    localparam int GIE_BIT  = 31;
    localparam logic [DATA_W-1:0] SRST_KEY = 32'h0000_000A;
endpackage

// File: rtl/pir_soft_reset.sv
module pir_soft_reset #(
    parameter int RST_CYC = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic key_wr_i,
    output logic srst_o
);
    localparam int CW = $clog2(RST_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (key_wr_i) begin
            st_d.cnt = CW'(RST_CYC);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign srst_o = (st_q.cnt != '0);

    // R1: a key write raises the pulse on the next cycle
    a_r1_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
        key_wr_i |=> srst_o);
    // R2: the pulse never begins without a key write
    a_r2_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!srst_o && !key_wr_i) |=> !srst_o);
endmodule

// File: rtl/pir_status.sv
module pir_status #(
    parameter int EVT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             rd_clr_i,
    input  logic [EVT_W-1:0] evt_i,
    output logic [EVT_W-1:0] flags_o
);
    typedef struct packed {
        logic [EVT_W-1:0] flags;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.flags = '0;
        end else begin
            st_d.flags = (rd_clr_i ? '0 : st_q.flags) | evt_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign flags_o = st_q.flags;

    // R7: an event coinciding with the clearing read is kept
    a_r7_keep_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_i && evt_i != '0) |=> ((flags_o & $past(evt_i)) == $past(evt_i)));
    // R7: a read with no event empties the flags
    a_r7_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_clr_i && evt_i == '0) |=> (flags_o == '0));
endmodule

// File: rtl/pir_irq_regs.sv
module pir_irq_regs #(
    parameter int EVT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             gie_we_i,
    input  logic             gie_wdata_i,
    input  logic             ier_we_i,
    input  logic [EVT_W-1:0] ier_wdata_i,
    input  logic             isr_we_i,
    input  logic [EVT_W-1:0] isr_wdata_i,
    input  logic [EVT_W-1:0] evt_i,
    output logic             gie_o,
    output logic [EVT_W-1:0] ier_o,
    output logic [EVT_W-1:0] isr_o,
    output logic             irq_o
);
    typedef struct packed {
        logic             gie;
        logic [EVT_W-1:0] ier;
        logic [EVT_W-1:0] isr;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d = '0;
        end else begin
            if (gie_we_i) st_d.gie = gie_wdata_i;
            if (ier_we_i) st_d.ier = ier_wdata_i;
            st_d.isr = (st_q.isr ^ (isr_we_i ? isr_wdata_i : '0)) | evt_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign gie_o = st_q.gie;
    assign ier_o = st_q.ier;
    assign isr_o = st_q.isr;
    assign irq_o = st_q.gie && ((st_q.isr & st_q.ier) != '0) && !clr_i;

    // R5: a quiet acknowledge write inverts exactly the written ones
    a_r5_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (isr_we_i && !clr_i && evt_i == '0) |=> (isr_o == ($past(isr_o) ^ $past(isr_wdata_i))));
    // R9: a reset cycle leaves every register empty
    a_r9_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (!gie_o && ier_o == '0 && isr_o == '0));
endmodule

// File: rtl/periph_irq_regs.sv
module periph_irq_regs
    import pir_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int EVT_W    = 8,
    parameter int RST_CYC  = 16,
    parameter bit HAS_IRQ  = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic [EVT_W-1:0]  evt_i,
    output logic              irq_o,
    output logic              srst_o
);
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } state_t;

    state_t st_d, st_q;

    logic             hit_srst, hit_gie, hit_ier, hit_isr, hit_stat;
    logic             key_wr;
    logic             gie;
    logic [EVT_W-1:0] ier, isr, flags;
    logic             irq_raw;

    assign hit_srst = (addr_i == ADDR_W'(OFS_SRST));
    assign hit_gie  = (addr_i == ADDR_W'(OFS_GIE));
    assign hit_ier  = (addr_i == ADDR_W'(OFS_IER));
    assign hit_isr  = (addr_i == ADDR_W'(OFS_ISR));
    assign hit_stat = (addr_i == ADDR_W'(OFS_STAT));
    assign key_wr   = wr_en_i && hit_srst && (wr_data_i == SRST_KEY);

    pir_soft_reset #(.RST_CYC(RST_CYC)) u_srst (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .key_wr_i (key_wr),
        .srst_o   (srst_o)
    );

    pir_status #(.EVT_W(EVT_W)) u_stat (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clr_i    (srst_o),
        .rd_clr_i (rd_en_i && hit_stat),
        .evt_i    (evt_i),
        .flags_o  (flags)
    );

    generate
        if (HAS_IRQ) begin : g_irq
            pir_irq_regs #(.EVT_W(EVT_W)) u_irq (
                .clk_i       (clk_i),
                .rst_ni      (rst_ni),
                .clr_i       (srst_o),
                .gie_we_i    (wr_en_i && hit_gie),
                .gie_wdata_i (wr_data_i[GIE_BIT]),
                .ier_we_i    (wr_en_i && hit_ier),
                .ier_wdata_i (wr_data_i[EVT_W-1:0]),
                .isr_we_i    (wr_en_i && hit_isr),
                .isr_wdata_i (wr_data_i[EVT_W-1:0]),
                .evt_i       (evt_i),
                .gie_o       (gie),
                .ier_o       (ier),
                .isr_o       (isr),
                .irq_o       (irq_raw)
            );
        end else begin : g_no_irq
            assign gie     = 1'b0;
            assign ier     = '0;
            assign isr     = '0;
            assign irq_raw = 1'b0;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (rd_en_i) begin
            st_d.rdata = '0;
            if (hit_gie)  st_d.rdata[GIE_BIT] = gie;
            if (hit_ier)  st_d.rdata = DATA_W'(ier);
            if (hit_isr)  st_d.rdata = DATA_W'(isr);
            if (hit_stat) st_d.rdata = DATA_W'(flags);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rd_data_o = st_q.rdata;
    assign irq_o     = irq_raw;

    // R9: interrupt held low through the reset pulse
    a_r9_irq_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        srst_o |-> !irq_o);
    // R11: read data only moves after a read strobe
    a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> $stable(rd_data_o));
    // R6: an event outside the reset pulse reaches the status flags
    a_r6_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!srst_o && evt_i != '0) |=> ((flags & $past(evt_i)) == $past(evt_i)));
endmodule

// File: tb/periph_irq_regs_test.sv
module periph_irq_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  evt = '0;
    logic [31:0] rd_data, rd_data_b;
    logic        irq, irq_b, srst, srst_b;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    periph_irq_regs uut (
        .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
        .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_data_o(rd_data),
        .evt_i(evt), .irq_o(irq), .srst_o(srst));

    periph_irq_regs #(.HAS_IRQ(1'b0)) uut_noirq (
        .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
        .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_data_o(rd_data_b),
        .evt_i(evt), .irq_o(irq_b), .srst_o(srst_b));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] e);
        evt = e;
        @(negedge clk);
        evt = '0;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("reset irq R8", 32'(irq), 0);
        check("reset srst R1", 32'(srst), 0);
        for (int a = 0; a < 8; a++) begin
            rd(4'(a));
            check("reset read R11", rd_data, 0);
        end

        // R3, R4, R10: stored widths
        wr(1, 32'hFFFF_FFFF); rd(1);
        check("R3 gie readback", rd_data, 32'h8000_0000);
        check("R10 gie absent", rd_data_b, 0);
        wr(2, 32'hFFFF_FFFF); rd(2);
        check("R4 ier readback", rd_data, 32'h0000_00FF);
        check("R10 ier absent", rd_data_b, 0);
        wr(1, 0); wr(2, 0);
        rd(15);
        check("R11 unmapped", rd_data, 0);

        // sweep all event patterns
        for (int p = 0; p < 256; p++) begin
            logic [7:0] m;
            m = 8'((p * 37 + 11) & 255);
            pulse(8'(p));
            rd(4);
            check("R6 status latch", rd_data, 32'(p));
            check("R10 status still works", rd_data_b, 32'(p));
            rd(4);
            check("R7 read clears", rd_data, 0);
            rd(3);
            check("R6 isr latch", rd_data, 32'(p));
            check("R10 isr absent", rd_data_b, 0);
            wr(2, 32'(m)); wr(1, 32'h8000_0000);
            check("R8 irq", 32'(irq), 32'((8'(p) & m) != 0));
            check("R10 irq low", 32'(irq_b), 0);
            wr(1, 0);
            check("R3 gate off", 32'(irq), 0);
            wr(3, 32'(p)); rd(3);
            check("R5 toggle clear", rd_data, 0);
        end

        // R5 partial toggles
        wr(3, 32'h0F); rd(3);
        check("R5 toggle set", rd_data, 32'h0F);
        wr(3, 32'hFF); rd(3);
        check("R5 toggle mixed", rd_data, 32'hF0);
        wr(3, 32'hF0); rd(3);
        check("R5 toggle back", rd_data, 0);

        // R7 event in the same cycle as the clearing read
        pulse(8'h01);
        addr = 4; rd_en = 1'b1; evt = 8'h02;
        @(negedge clk);
        rd_en = 1'b0; evt = '0;
        check("R7 read value", rd_data, 32'h01);
        rd(4);
        check("R7 coincident event kept", rd_data, 32'h02);

        // R5 acknowledge write coinciding with an event
        rd(3);
        check("R5 isr before", rd_data, 32'h03);
        addr = 3; wr_data = 32'h03; wr_en = 1'b1; evt = 8'h01;
        @(negedge clk);
        wr_en = 1'b0; evt = '0;
        rd(3);
        check("R5 event wins", rd_data, 32'h01);
        wr(3, 32'h01);

        // R2 non-key values
        for (int k = 0; k < 5; k++) begin
            logic [31:0] v;
            logic seen;
            v = (k == 0) ? 32'h0 : (k == 1) ? 32'h9 : (k == 2) ? 32'hB :
                (k == 3) ? 32'h1A : 32'h8000_000A;
            wr(0, v);
            seen = 1'b0;
            for (int c = 0; c < 20; c++) begin
                if (srst) seen = 1'b1;
                @(negedge clk);
            end
            check("R2 no reset", 32'(seen), 0);
        end
        rd(0);
        check("R2 reads zero", rd_data, 0);

        // R1, R9 soft reset
        wr(1, 32'h8000_0000); wr(2, 32'hFF); pulse(8'h05);
        check("R8 irq before reset", 32'(irq), 1);
        wr(0, 32'h0000_000A);
        begin
            int n;
            logic irq_seen;
            n = 0; irq_seen = 1'b0;
            while (srst && n < 100) begin
                if (irq) irq_seen = 1'b1;
                evt = (n == 5) ? 8'h03 : 8'h00;
                wr_en = (n == 5); addr = 2; wr_data = 32'hFF;
                @(negedge clk);
                n++;
            end
            evt = '0; wr_en = 1'b0;
            check("R1 pulse length", 32'(n), 16);
            check("R9 irq low", 32'(irq_seen), 0);
        end
        check("R9 irq after", 32'(irq), 0);
        rd(1); check("R9 gie zero", rd_data, 0);
        rd(2); check("R9 ier zero", rd_data, 0);
        rd(3); check("R9 isr zero", rd_data, 0);
        rd(4); check("R9 status zero", rd_data, 0);
        check("R1 second instance", 32'(srst_b), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule